// File: doc/BRIEF.md
# Bit-Granular PCM Frame Serializer

This block is the serial side of a PCM audio port that runs as clock master. It divides the system clock down to a bit clock, counts bit positions inside a frame, raises a frame-sync pulse at the start of each frame, and shifts out two transmit samples in two slots. The same bit count steers the capture of two receive slots from the serial input. Frame length, sync length and the start and width of every slot are all programmed through a simple write port in units of one bit clock. This lets one block produce DSP-style short-sync framing, long multi-slot TDM-like frames in which only two slots carry data, and many layouts in between.

Software fills the configuration registers while the port is idle and then sets the enable bit. Writes made while the port is running are held in shadow registers and take effect at the next frame boundary, so a frame is never built from a mix of old and new settings. Each frame, the block asks for the next pair of transmit samples with a one-cycle pulse and delivers the two received words, optionally sign-extended, with another one-cycle pulse.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, and at all times while the active enable bit (control register, address 6, bit 0) is clear, `bclk`, `fsync`, `dout`, `tx_ready` and `rx_valid` are all 0.
- R2: While enabled, `bclk` is high for BCLK_HALF and low for BCLK_HALF clock cycles. `dout` and `fsync` change only as `bclk` falls. `din` is sampled as `bclk` rises. The first falling edge comes 5 clock cycles after the clock edge that writes the enable bit while the port is idle (BCLK_HALF = 2).
- R3: The frame length in bits is written to address 0 in bits [11:0]. The frame repeats every that many bit clocks, and lengths above 1024 bits are supported up to 4095.
- R4: The sync length is written to address 1 in bits [11:0]. `fsync` is high for frame bit positions 0 up to sync length − 1 and low elsewhere. A sync length of 1 with a slot starting at 0 gives a one-bit sync pulse that shares its bit clock with the first data bit.
- R5: Transmit slots 0 and 1 are programmed at addresses 2 and 3, with start bit position in bits [11:0] and width in bits [17:12]. Width 0 disables the slot, and widths above 32 act as 32. A slot sends the low `width` bits of its sample MSB first, starting at the start position. Where the two slots overlap, slot 0 drives the line.
- R6: Every bit position outside both transmit slots drives 0 on `dout`.
- R7: A transmit slot whose start plus width goes past the frame length is cut at the last bit of the frame. Its remaining bits are never sent.
- R8: `tx_word0`/`tx_word1` are captured in the clock cycle of the rising bit-clock edge that samples the last bit of a frame, and are sent in the following frame. `tx_ready` is high for exactly that one following clock cycle. For the first frame after enabling, the words present while idle are used.
- R9: Receive slots 0 and 1 are programmed at addresses 4 and 5 in the same field layout as R5. The bits of each slot are assembled MSB first. Once the last bit of the frame has been sampled, `rx_word0`/`rx_word1` are updated and `rx_valid` is high for one cycle. A slot cut by the frame end delivers the captured bits right-aligned.
- R10: When the sign-extend bit (address 6, bit 1) is set, each received word is sign-extended from bit width − 1 to 32 bits. When it is clear, the bits above the width are 0. A width-0 slot reads as 0.
- R11: Register writes made while running, including clearing the enable bit, take effect from the first bit of the next frame. The frame in progress keeps its settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 18 | Register write data |
| tx_word0 | input | 32 | Transmit sample for slot 0 |
| tx_word1 | input | 32 | Transmit sample for slot 1 |
| tx_ready | output | 1 | One-cycle pulse: transmit pair captured, present the next |
| din | input | 1 | Serial data input |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| dout | output | 1 | Serial data output |
| rx_word0 | output | 32 | Received word from slot 0 |
| rx_word1 | output | 32 | Received word from slot 1 |
| rx_valid | output | 1 | One-cycle pulse: received words updated |

## Verification
The bench targets overlapping transmit slots and slots running past the frame end. A design with the wrong priority or no truncation would put slot 1 bits in slot 0's window, or would spill the leftover bits into the next frame's first positions. It covers a 1100-bit frame with a slot beyond bit 1024, where a counter that is too narrow would wrap early and shift the whole frame. It also changes the frame length and clears enable mid-frame. A design that applied writes at once would shorten or stop the running frame, and the per-cycle comparison shows this at the exact bit. Receive words are checked with sign extension on and off and with a truncated slot. This exposes sign taken from the wrong bit and leftover bits from the previous frame.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;
  localparam int POS_W  = 12;             // bit position / frame length width
  localparam int SMP_W  = 32;             // sample width
  localparam int WID_W  = 6;              // slot width field
  localparam int IDX_W  = $clog2(SMP_W);
  localparam int ADDR_W = 3;
  localparam int DATA_W = POS_W + WID_W;

  typedef struct packed {
    logic [WID_W-1:0] width;
    logic [POS_W-1:0] start;
  } slot_t;

  typedef struct packed {
    logic             enable;
    logic             sext;
    logic [POS_W-1:0] flen;
    logic [POS_W-1:0] slen;
    slot_t            tx0;
    slot_t            tx1;
    slot_t            rx0;
    slot_t            rx1;
  } cfg_t;

  function automatic logic in_slot(slot_t s, logic [POS_W-1:0] p);
    logic [POS_W:0] endp;
    endp = {1'b0, s.start} + (POS_W+1)'(s.width);
    return (s.width != '0) && (p >= s.start) && ({1'b0, p} < endp);
  endfunction

  function automatic logic [IDX_W-1:0] slot_index(slot_t s, logic [POS_W-1:0] p);
    logic [WID_W-1:0] r;
    r = s.width - 1'b1 - WID_W'(p - s.start);
    return IDX_W'(r);
  endfunction

  function automatic logic [WID_W-1:0] clamp_width(logic [WID_W-1:0] v);
    return (v > WID_W'(SMP_W)) ? WID_W'(SMP_W) : v;
  endfunction

  function automatic logic [SMP_W-1:0] sign_fill(logic [SMP_W-1:0] v, logic [WID_W-1:0] w,
                                                 logic se);
    logic [SMP_W-1:0] r;
    logic sb;
    sb = (w != '0) ? v[IDX_W'(w - 1'b1)] : 1'b0;
    for (int i = 0; i < SMP_W; i++) r[i] = (i < int'(w)) ? v[i] : (se & sb);
    return r;
  endfunction
endpackage

// File: rtl/pcm_cfg_regs.sv
`timescale 1ns/1ps
module pcm_cfg_regs
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  output cfg_t              act
);
  cfg_t  shad;
  slot_t wslot;

  always_comb begin
    wslot.start = wdata[POS_W-1:0];
    wslot.width = clamp_width(wdata[DATA_W-1:POS_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shad      <= '0;
      shad.flen <= POS_W'(64);
      shad.slen <= POS_W'(1);
    end else if (we) begin
      case (addr)
        3'd0: shad.flen <= wdata[POS_W-1:0];
        3'd1: shad.slen <= wdata[POS_W-1:0];
        3'd2: shad.tx0  <= wslot;
        3'd3: shad.tx1  <= wslot;
        3'd4: shad.rx0  <= wslot;
        3'd5: shad.rx1  <= wslot;
        3'd6: begin
          shad.enable <= wdata[0];
          shad.sext   <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= '0;
      act.flen <= POS_W'(64);
      act.slen <= POS_W'(1);
    end else if (load) begin
      act <= shad;
    end
  end
endmodule

// File: rtl/pcm_bit_timer.sv
`timescale 1ns/1ps
module pcm_bit_timer
  import pcm_port_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [POS_W-1:0] flen,
  output logic             bclk,
  output logic             fall_tick,
  output logic             rise_tick,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] cur_bit,
  output logic             have_bit
);
  localparam int DW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  logic [DW-1:0] dcnt;
  logic          step;

  assign step      = run && (dcnt == DW'(BCLK_HALF - 1));
  assign fall_tick = step && bclk;
  assign rise_tick = step && !bclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      dcnt     <= '0;
      bclk     <= 1'b0;
      pos      <= '0;
      cur_bit  <= '0;
      have_bit <= 1'b0;
    end else if (step) begin
      dcnt <= '0;
      bclk <= ~bclk;
      if (bclk) begin
        cur_bit  <= pos;
        have_bit <= 1'b1;
        pos      <= (pos == flen - 1'b1) ? '0 : pos + 1'b1;
      end
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (flen != '0) |-> (pos < flen)); // R3
  AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !bclk); // R1
endmodule

// File: rtl/pcm_tx_slots.sv
`timescale 1ns/1ps
module pcm_tx_slots
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             latch,
  input  logic             fall_tick,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] slen,
  input  slot_t            slot0,
  input  slot_t            slot1,
  input  logic [SMP_W-1:0] word0,
  input  logic [SMP_W-1:0] word1,
  output logic             dout,
  output logic             fsync
);
  logic [SMP_W-1:0] hold0, hold1;
  logic             hit0, hit1, nxt_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold0 <= '0;
      hold1 <= '0;
    end else if (latch) begin
      hold0 <= word0;
      hold1 <= word1;
    end
  end

  always_comb begin
    hit0 = in_slot(slot0, pos);
    hit1 = in_slot(slot1, pos);
    if (hit0)      nxt_bit = hold0[slot_index(slot0, pos)];
    else if (hit1) nxt_bit = hold1[slot_index(slot1, pos)];
    else           nxt_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      dout  <= 1'b0;
      fsync <= 1'b0;
    end else if (fall_tick) begin
      dout  <= nxt_bit;
      fsync <= (pos < slen);
    end
  end
endmodule

// File: rtl/pcm_rx_slots.sv
`timescale 1ns/1ps
module pcm_rx_slots
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sample,
  input  logic             frame_end,
  input  logic [POS_W-1:0] cur_bit,
  input  logic             din,
  input  slot_t            slot0,
  input  slot_t            slot1,
  input  logic             sext,
  output logic [SMP_W-1:0] word0,
  output logic [SMP_W-1:0] word1,
  output logic             valid
);
  logic [SMP_W-1:0] sh0, sh1, base0, base1, nxt0, nxt1;

  always_comb begin
    base0 = (cur_bit == '0) ? '0 : sh0;
    base1 = (cur_bit == '0) ? '0 : sh1;
    nxt0  = in_slot(slot0, cur_bit) ? {base0[SMP_W-2:0], din} : base0;
    nxt1  = in_slot(slot1, cur_bit) ? {base1[SMP_W-2:0], din} : base1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh0   <= '0;
      sh1   <= '0;
      word0 <= '0;
      word1 <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (sample) begin
        sh0 <= nxt0;
        sh1 <= nxt1;
        if (frame_end) begin
          word0 <= sign_fill(nxt0, slot0.width, sext);
          word1 <= sign_fill(nxt1, slot1.width, sext);
          valid <= 1'b1;
        end
      end
    end
  end

  AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R9
endmodule

// File: rtl/pcm_frame_port.sv
`timescale 1ns/1ps
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SMP_W-1:0]  tx_word0,
  input  logic [SMP_W-1:0]  tx_word1,
  output logic              tx_ready,
  input  logic              din,
  output logic              bclk,
  output logic              fsync,
  output logic              dout,
  output logic [SMP_W-1:0]  rx_word0,
  output logic [SMP_W-1:0]  rx_word1,
  output logic              rx_valid
);
  cfg_t             act;
  logic             fall_tick, rise_tick, have_bit, end_tick, load, sample;
  logic [POS_W-1:0] pos, cur_bit;

  assign sample   = rise_tick && have_bit;
  assign end_tick = sample && (cur_bit == act.flen - 1'b1);
  assign load     = !act.enable || end_tick;

  pcm_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .act(act)
  );

  pcm_bit_timer #(.BCLK_HALF(BCLK_HALF)) u_timer (
    .clk(clk), .rst(rst), .run(act.enable), .flen(act.flen), .bclk(bclk),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .pos(pos),
    .cur_bit(cur_bit), .have_bit(have_bit)
  );

  pcm_tx_slots u_tx (
    .clk(clk), .rst(rst), .run(act.enable), .latch(load), .fall_tick(fall_tick),
    .pos(pos), .slen(act.slen), .slot0(act.tx0), .slot1(act.tx1),
    .word0(tx_word0), .word1(tx_word1), .dout(dout), .fsync(fsync)
  );

  pcm_rx_slots u_rx (
    .clk(clk), .rst(rst), .sample(sample), .frame_end(end_tick),
    .cur_bit(cur_bit), .din(din), .slot0(act.rx0), .slot1(act.rx1),
    .sext(act.sext), .word0(rx_word0), .word1(rx_word1), .valid(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_ready <= 1'b0;
    else     tx_ready <= end_tick;
  end

  AST_DOUT_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (bclk && $past(bclk)) |-> $stable(dout)); // R2
  AST_SYNC_AT_BIT0: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> (cur_bit == '0)); // R4
  AST_TXRDY_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready); // R8
  AST_TXRDY_WITH_RX: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> rx_valid); // R8
endmodule

// File: tb/test_pcm_frame_port.sv
`timescale 1ns/1ps
module test_pcm_frame_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [17:0] cfg_wdata = '0;
  logic [31:0] tx_word0 = '0, tx_word1 = '0;
  logic        din = 1'b0;
  logic        tx_ready, bclk, fsync, dout, rx_valid;
  logic [31:0] rx_word0, rx_word1;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  // model configuration: 0 flen,1 slen,2 ts0,3 tw0,4 ts1,5 tw1,6 rs0,7 rw0,8 rs1,9 rw1,10 sext
  int cur[11];
  int pend[11];

  always #5 clk = ~clk;

  pcm_frame_port i_pcm_frame_port (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_word0(tx_word0), .tx_word1(tx_word1), .tx_ready(tx_ready), .din(din),
    .bclk(bclk), .fsync(fsync), .dout(dout), .rx_word0(rx_word0), .rx_word1(rx_word1),
    .rx_valid(rx_valid)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] smp(int ch, int f);
    logic [31:0] v;
    if (ch == 0) v = 32'h8000_0001 ^ (32'(f + 1) * 32'h9E37_79B9);
    else         v = 32'h0135_7F00 + (32'(f + 3) * 32'h7F4A_7C15);
    return v;
  endfunction

  function automatic logic dpat(int f, int p);
    return ((p * 37 + f * 11 + (p >> 2)) % 5) < 2;
  endfunction

  function automatic bit in_s(int s, int w, int p);
    return (w > 0) && (p >= s) && (p < s + w);
  endfunction

  function automatic logic exp_dout(int f, int p);
    logic [31:0] v;
    if (in_s(cur[2], cur[3], p)) begin
      v = smp(0, f);
      return v[cur[3] - 1 - (p - cur[2])];
    end
    if (in_s(cur[4], cur[5], p)) begin
      v = smp(1, f);
      return v[cur[5] - 1 - (p - cur[4])];
    end
    return 1'b0;
  endfunction

  function automatic longint exp_rx(longint acc, int w, int se);
    longint mask;
    if (w == 0) return 0;
    mask = (64'd1 << w) - 1;
    acc = acc & mask;
    if (se != 0 && acc[w-1]) acc = acc | (64'hFFFF_FFFF & ~mask);
    return acc;
  endfunction

  // decode of register writes as specified in R3, R4, R5, R9, R10
  task automatic model_write(int a, int d, bit idle);
    int w;
    w = (d >> 12) & 63;
    if (w > 32) w = 32;
    case (a)
      0: pend[0] = d & 12'hFFF;
      1: pend[1] = d & 12'hFFF;
      2: begin pend[2] = d & 12'hFFF; pend[3] = w; end
      3: begin pend[4] = d & 12'hFFF; pend[5] = w; end
      4: begin pend[6] = d & 12'hFFF; pend[7] = w; end
      5: begin pend[8] = d & 12'hFFF; pend[9] = w; end
      6: pend[10] = (d >> 1) & 1;
      default: ;
    endcase
    if (idle) cur = pend;
  endtask

  task automatic idle_check(string req);
    chk(req, "bclk idle", longint'(bclk), 0);
    chk(req, "fsync idle", longint'(fsync), 0);
    chk(req, "dout idle", longint'(dout), 0);
    chk(req, "tx_ready idle", longint'(tx_ready), 0);
    chk(req, "rx_valid idle", longint'(rx_valid), 0);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr_idle(int a, int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 18'(d);
    model_write(a, d, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
    idle_check("R1");
  endtask

  function automatic int sl(int start, int width);
    return (width << 12) | start;
  endfunction

  task automatic setup(int flen, int slen, int ts0, int tw0, int ts1, int tw1,
                       int rs0, int rw0, int rs1, int rw1, int se);
    wr_idle(0, flen);
    wr_idle(1, slen);
    wr_idle(2, sl(ts0, tw0));
    wr_idle(3, sl(ts1, tw1));
    wr_idle(4, sl(rs0, rw0));
    wr_idle(5, sl(rs1, rw1));
    wr_idle(6, se << 1);
  endtask

  task automatic run_test(int nfr, int chg_f, int chg_a, int chg_d);
    longint acc0, acc1;
    int fl;
    bit last;
    tx_word0 = smp(0, 0);
    tx_word1 = smp(1, 0);
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 18'((cur[10] << 1) | 1);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    for (int f = 0; f < nfr; f++) begin
      if (f > 0) cur = pend;
      fl = cur[0];
      acc0 = 0; acc1 = 0;
      for (int p = 0; p < fl; p++) begin
        for (int ph = 0; ph < 4; ph++) begin
          last = (f == nfr - 1) && (p == fl - 1);
          if (!(last && ph == 3)) begin
            chk("R2", "bclk", longint'(bclk), (ph >= 2) ? 1 : 0);
            chk("R4", "fsync", longint'(fsync), (p < cur[1]) ? 1 : 0);
            chk("R6", "dout", longint'(dout), longint'(exp_dout(f, p)));
            chk("R8", "tx_ready", longint'(tx_ready), (p == fl - 1 && ph == 2) ? 1 : 0);
            chk("R9", "rx_valid", longint'(rx_valid), (p == fl - 1 && ph == 2) ? 1 : 0);
            if (p == fl - 1 && ph == 2) begin
              chk("R10", "rx_word0", longint'(rx_word0), exp_rx(acc0, cur[7], cur[10]));
              chk("R10", "rx_word1", longint'(rx_word1), exp_rx(acc1, cur[9], cur[10]));
            end
          end
          cfg_we = 1'b0;
          if (ph == 0) begin
            din = dpat(f, p);
            if (in_s(cur[6], cur[7], p)) acc0 = (acc0 << 1) | longint'(din);
            if (in_s(cur[8], cur[9], p)) acc1 = (acc1 << 1) | longint'(din);
            if (p == 0) begin
              tx_word0 = smp(0, f + 1);
              tx_word1 = smp(1, f + 1);
            end
            if (f == chg_f && p == fl / 2) begin
              cfg_we = 1'b1; cfg_addr = 3'(chg_a); cfg_wdata = 18'(chg_d);
              model_write(chg_a, chg_d, 1'b0);
            end
          end
          if (ph == 2 && f == nfr - 1 && p == fl / 2) begin
            // R11: disable requested mid-frame, honoured at the frame end
            cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 18'(cur[10] << 1);
          end
          @(negedge clk);
        end
      end
    end
    cfg_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      idle_check("R11");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    idle_check("R1");   // reset state
    rst = 1'b0;
    @(negedge clk);
    idle_check("R1");
    for (int i = 0; i < 11; i++) begin cur[i] = 0; pend[i] = 0; end
    cur[0] = 64; cur[1] = 1; pend = cur;

    // R4 and R5: DSP framing, one-bit sync with data starting at bit 0; R10 sign extension on
    setup(64, 1, 0, 16, 32, 16, 0, 16, 32, 16, 1);
    run_test(3, -1, 0, 0);

    // R5 overlap priority and width clamp (45 -> 32), R7 truncation, R9 truncated rx, no extension
    setup(40, 6, 10, 12, 16, 45, 30, 20, 3, 32, 0);
    run_test(3, -1, 0, 0);

    // R3: 1100-bit frame with data beyond bit 1024
    setup(1100, 3, 1060, 32, 0, 0, 1068, 32, 100, 8, 1);
    run_test(2, -1, 0, 0);

    // R11: frame length change written mid-frame applies from the next frame
    setup(48, 2, 4, 8, 20, 10, 2, 12, 25, 9, 1);
    run_test(3, 0, 0, 36);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule